// File: doc/BRIEF.md
# MSI-X Capability Configuration Registers

This block holds the twelve-byte MSI-X capability structure that a function exposes in its PCI configuration space. It answers configuration reads inside the capability window and applies configuration writes to it. Most of the structure is fixed: the capability identifier, the link to the next capability, the table size and the two location dwords that point at the vector table and the pending-bit array inside one memory BAR. Software can change only two bits, the global enable and the function-wide mask.

The two bits, and the table size, are sent to the vector table controller. When a write lifts masking, the block raises `scan_req` for one cycle. Masking is lifted when the enable bit goes from 0 to 1 or when the function mask goes from 1 to 0. On that pulse the table controller sends any vectors that became pending while delivery was blocked. The configuration router passes in the byte offset inside the window and an access length of 1, 2 or 4 bytes. A read is answered in the same cycle. A write takes effect at the next clock edge.

Top module: `msixcap_cfg`

## Requirements
- R1: Offset 0 reads 0x11 and offset 1 reads the `NEXT_PTR` parameter. Writes never change either byte.
- R2: Message control bits 10:0 (offsets 2 and 3) read `VEC_COUNT`-1 and cannot be written. The `tbl_size` output equals that field plus one.
- R3: Bit 15 of message control (bit 7 of offset 3) is the enable and bit 14 is the function mask. A write to offset 3 updates both from the written byte. Bits 13:11 always read 0 and bits 10:8 keep their fixed value.
- R4: The dword at offset 4 reads `BAR_IDX` in bits 2:0 with a table offset of 0. The dword at offset 8 reads 0x800 | `BAR_IDX`. Writes do not change either dword.
- R5: A write with length N (`cfg_len` = 1, 2 or 4) covers offsets `cfg_addr` to `cfg_addr`+N-1. Byte k of the range takes `cfg_wdata[8k+7:8k]`. Data lanes outside the range have no effect.
- R6: A read returns offsets `cfg_addr` upward, little-endian, in the low `cfg_len` bytes of `cfg_rdata`. The higher lanes read 0. Offsets 12 and above read 0.
- R7: After reset, the enable and the function mask are 0 and `scan_req` is 0.
- R8: A write that moves the enable from 0 to 1 makes `scan_req` high for the single cycle after the write edge.
- R9: A write that moves the function mask from 1 to 0 makes `scan_req` high for the single cycle after the write edge.
- R10: No other write raises `scan_req`. This covers writes that set the mask, writes that clear the enable, writes that leave both bits unchanged, and writes to other offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Write strobe for one cycle |
| cfg_addr | input | 4 | Byte offset inside the capability |
| cfg_len | input | 3 | Access length in bytes (1, 2 or 4) |
| cfg_wdata | input | 32 | Write data, lane 0 goes to `cfg_addr` |
| cfg_rdata | output | 32 | Read data, combinational from address and length |
| msix_en | output | 1 | Global enable |
| func_mask | output | 1 | Function-wide mask |
| tbl_size | output | 12 | Number of table entries |
| scan_req | output | 1 | One-cycle request to rescan pending vectors |

## Verification
The bench builds the block with `VEC_COUNT` = 292, `BAR_IDX` = 5 and `NEXT_PTR` = 0xA4. With a table size minus one of 0x123, the fixed bits 10:8 share offset 3 with the two writable bits. A write to that byte therefore shows whether the fixed bits are really kept. The nonzero BAR index shows up in both location dwords, so a swapped or missing field can be seen. A non-zero next pointer can be told apart from a cleared byte.

// File: rtl/msixcap_pkg.sv
package msixcap_pkg;

    localparam int          CAP_BYTES = 12;
    localparam logic [7:0]  CAP_ID    = 8'h11;
    localparam logic [4:0]  CTRL_HI   = 5'd3;
    localparam int          SZ_W      = 11;

    typedef struct packed {
        logic en;
        logic fmask;
    } ctrl_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] data;
    } hi_wr_t;

    // Byte of the capability image at a given offset.
    function automatic logic [7:0] image_byte(
        input logic [4:0]      ofs,
        input logic [7:0]      nxt,
        input logic [SZ_W-1:0] sz_m1,
        input logic [2:0]      bir,
        input ctrl_t           c
    );
        logic [7:0] b;
        case (ofs)
            5'd0:    b = CAP_ID;
            5'd1:    b = nxt;
            5'd2:    b = sz_m1[7:0];
            5'd3:    b = {c.en, c.fmask, 3'b000, sz_m1[10:8]};
            5'd4:    b = {5'b0, bir};
            5'd8:    b = {5'b0, bir};
            5'd9:    b = 8'h08;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/msixcap_wr_decode.sv
module msixcap_wr_decode
    import msixcap_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               wr,
    input  logic [3:0]         addr,
    input  logic [2:0]         len,
    input  logic [8*LANES-1:0] wdata,
    output hi_wr_t             hi
);
    logic [LANES-1:0] lane_hit;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [4:0] tgt;
        assign tgt         = {1'b0, addr} + 5'(i);
        assign lane_hit[i] = wr && (3'(i) < len) && (tgt == CTRL_HI);
    end

    always_comb begin
        hi.hit  = |lane_hit;
        hi.data = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            if (lane_hit[i]) hi.data = hi.data | wdata[8*i +: 8];
        end
    end
endmodule

// File: rtl/msixcap_ctrl_reg.sv
module msixcap_ctrl_reg
    import msixcap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  hi_wr_t hi,
    output ctrl_t  ctrl,
    output logic   scan
);
    logic new_en, new_mask, lifts;

    assign new_en   = hi.data[7];
    assign new_mask = hi.data[6];
    assign lifts    = (!ctrl.en && new_en) || (ctrl.fmask && !new_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            scan <= 1'b0;
        end else begin
            scan <= hi.hit && lifts;
            if (hi.hit) begin
                ctrl.en    <= new_en;
                ctrl.fmask <= new_mask;
            end
        end
    end
endmodule

// File: rtl/msixcap_rd_mux.sv
module msixcap_rd_mux
    import msixcap_pkg::*;
#(
    parameter int         LANES    = 4,
    parameter logic [7:0] NEXT_PTR = 8'h00,
    parameter int         SZ_M1    = 0,
    parameter int         BAR_IDX  = 0
) (
    input  logic [3:0]         addr,
    input  logic [2:0]         len,
    input  ctrl_t              ctrl,
    output logic [8*LANES-1:0] rdata
);
    localparam logic [SZ_W-1:0] SZ_F  = SZ_W'(SZ_M1);
    localparam logic [2:0]      BIR_F = 3'(BAR_IDX);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [4:0] ofs;
        assign ofs = {1'b0, addr} + 5'(i);
        assign rdata[8*i +: 8] = (3'(i) < len)
            ? image_byte(ofs, NEXT_PTR, SZ_F, BIR_F, ctrl) : 8'h00;
    end
endmodule

// File: rtl/msixcap_cfg.sv
module msixcap_cfg
    import msixcap_pkg::*;
#(
    parameter int         MAX_VEC   = 2048,
    parameter int         VEC_COUNT = 8,
    parameter int         BAR_IDX   = 0,
    parameter logic [7:0] NEXT_PTR  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_addr,
    input  logic [2:0]  cfg_len,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        msix_en,
    output logic        func_mask,
    output logic [11:0] tbl_size,
    output logic        scan_req
);
    localparam int LANES = 4;
    localparam int SZ_M1 = VEC_COUNT - 1;

    if (BAR_IDX < 0 || BAR_IDX > 5) begin : g_bad_bar
        $error("msixcap_cfg: BAR_IDX out of range");
    end
    if (VEC_COUNT < 1 || VEC_COUNT > MAX_VEC || MAX_VEC > 2048) begin : g_bad_cnt
        $error("msixcap_cfg: VEC_COUNT out of range");
    end

    hi_wr_t hi;
    ctrl_t  ctrl;

    msixcap_wr_decode #(.LANES(LANES)) u_dec (
        .wr    (cfg_wr),
        .addr  (cfg_addr),
        .len   (cfg_len),
        .wdata (cfg_wdata),
        .hi    (hi)
    );

    msixcap_ctrl_reg u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .hi   (hi),
        .ctrl (ctrl),
        .scan (scan_req)
    );

    msixcap_rd_mux #(
        .LANES    (LANES),
        .NEXT_PTR (NEXT_PTR),
        .SZ_M1    (SZ_M1),
        .BAR_IDX  (BAR_IDX)
    ) u_rd (
        .addr  (cfg_addr),
        .len   (cfg_len),
        .ctrl  (ctrl),
        .rdata (cfg_rdata)
    );

    assign msix_en   = ctrl.en;
    assign func_mask = ctrl.fmask;
    assign tbl_size  = 12'(VEC_COUNT);
endmodule

// File: rtl/msixcap_cfg_chk.sv
module msixcap_cfg_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [3:0]  cfg_addr,
    input logic [2:0]  cfg_len,
    input logic [31:0] cfg_rdata,
    input logic        msix_en,
    input logic        func_mask,
    input logic        scan_req
);
    // R1: the identifier byte is fixed
    assert_cap_id_R1: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 4'd0 && cfg_len == 3'd1) |-> (cfg_rdata == 32'h0000_0011));

    // R5: the control bits move only on a write
    assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> ($stable(msix_en) && $stable(func_mask)));

    // R8: an enable rise is paired with a scan request
    assert_scan_on_enable_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(msix_en) |-> scan_req);

    // R9: a mask release is paired with a scan request
    assert_scan_on_unmask_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(func_mask) |-> scan_req);

    // R10: a scan request always follows a write
    assert_scan_needs_write_R10: assert property (@(posedge clk) disable iff (rst)
        scan_req |-> $past(cfg_wr));

    // R10: after a scan request, delivery is no longer blocked by both bits
    assert_scan_state_R10: assert property (@(posedge clk) disable iff (rst)
        scan_req |-> (msix_en || !func_mask));
endmodule

bind msixcap_cfg msixcap_cfg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_len   (cfg_len),
    .cfg_rdata (cfg_rdata),
    .msix_en   (msix_en),
    .func_mask (func_mask),
    .scan_req  (scan_req)
);

// File: tb/msixcap_cfg_test.sv
module msixcap_cfg_test;
    localparam int         VEC_N = 292;
    localparam int         BAR_N = 5;
    localparam logic [7:0] NXT_N = 8'hA4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [2:0]  cfg_len = 3'd1;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        msix_en, func_mask, scan_req;
    logic [11:0] tbl_size;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    msixcap_cfg #(
        .MAX_VEC(2048), .VEC_COUNT(VEC_N), .BAR_IDX(BAR_N), .NEXT_PTR(NXT_N)
    ) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .msix_en(msix_en), .func_mask(func_mask), .tbl_size(tbl_size),
        .scan_req(scan_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write on the next edge; returns at the following falling edge.
    task automatic wr(input logic [3:0] a, input logic [2:0] n, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_len = n; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [2:0] n, output logic [31:0] d);
        cfg_addr = a; cfg_len = n;
        #1;
        d = cfg_rdata;
    endtask

    // Checks the state and the pulse right after a write, then the pulse drop.
    task automatic after_wr(input string req, input logic en, input logic mk, input logic sc);
        chk({req, " enable"}, 32'(msix_en), 32'(en));
        chk({req, " mask"}, 32'(func_mask), 32'(mk));
        chk({req, " scan"}, 32'(scan_req), 32'(sc));
        @(negedge clk);
        chk({req, " scan drop"}, 32'(scan_req), 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R7 enable", 32'(msix_en), 32'h0);
        chk("R7 mask", 32'(func_mask), 32'h0);
        chk("R7 scan", 32'(scan_req), 32'h0);
        chk("R2 tbl_size", 32'(tbl_size), 32'd292);
        rd(4'd0, 3'd4, d);
        chk("R1 R2 dword0", d, 32'h0123_A411);
    endtask

    task automatic t_fixed_bytes;
        logic [31:0] d;
        wr(4'd0, 3'd2, 32'h0000_FFFF);
        after_wr("R1 R10 id write", 1'b0, 1'b0, 1'b0);
        rd(4'd0, 3'd4, d);
        chk("R1 id and next", d, 32'h0123_A411);
    endtask

    task automatic t_enable_mask;
        logic [31:0] d;
        wr(4'd3, 3'd1, 32'h0000_0080);
        after_wr("R8 enable rise", 1'b1, 1'b0, 1'b1);
        rd(4'd3, 3'd1, d);
        chk("R3 ctrl high byte", d, 32'h0000_0081);
        wr(4'd3, 3'd1, 32'h0000_00C0);
        after_wr("R10 mask set", 1'b1, 1'b1, 1'b0);
        wr(4'd3, 3'd1, 32'h0000_00C0);
        after_wr("R10 unchanged", 1'b1, 1'b1, 1'b0);
        wr(4'd3, 3'd1, 32'h0000_0080);
        after_wr("R9 mask release", 1'b1, 1'b0, 1'b1);
        wr(4'd3, 3'd1, 32'h0000_003F);
        after_wr("R10 enable clear", 1'b0, 1'b0, 1'b0);
        rd(4'd2, 3'd2, d);
        chk("R3 fixed bits kept", d, 32'h0000_0123);
        wr(4'd3, 3'd1, 32'h0000_0040);
        after_wr("R10 mask set while off", 1'b0, 1'b1, 1'b0);
        wr(4'd3, 3'd1, 32'h0000_0000);
        after_wr("R9 mask release while off", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_locations;
        logic [31:0] d;
        rd(4'd4, 3'd4, d);
        chk("R4 table dword", d, 32'h0000_0005);
        rd(4'd8, 3'd4, d);
        chk("R4 pba dword", d, 32'h0000_0805);
        wr(4'd4, 3'd4, 32'hFFFF_FFFF);
        after_wr("R10 table write", 1'b0, 1'b0, 1'b0);
        wr(4'd8, 3'd4, 32'hFFFF_FFFF);
        after_wr("R10 pba write", 1'b0, 1'b0, 1'b0);
        rd(4'd4, 3'd4, d);
        chk("R4 table kept", d, 32'h0000_0005);
        rd(4'd8, 3'd4, d);
        chk("R4 pba kept", d, 32'h0000_0805);
    endtask

    task automatic t_lanes;
        wr(4'd0, 3'd4, 32'h8000_0000);
        after_wr("R5 dword write lane 3", 1'b1, 1'b0, 1'b1);
        wr(4'd2, 3'd2, 32'h0000_0000);
        after_wr("R5 word write lane 1", 1'b0, 1'b0, 1'b0);
        wr(4'd2, 3'd1, 32'h0000_C000);
        after_wr("R5 lane beyond length", 1'b0, 1'b0, 1'b0);
        wr(4'd3, 3'd2, 32'h0000_0080);
        after_wr("R5 word at offset 3", 1'b1, 1'b0, 1'b1);
        wr(4'd1, 3'd2, 32'h0000_00FF);
        after_wr("R5 short of offset 3", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_reads;
        logic [31:0] d;
        rd(4'd1, 3'd2, d);
        chk("R6 word at 1", d, 32'h0000_23A4);
        rd(4'd2, 3'd1, d);
        chk("R6 byte lanes zero", d, 32'h0000_0023);
        rd(4'd9, 3'd1, d);
        chk("R6 byte at 9", d, 32'h0000_0008);
        rd(4'd8, 3'd2, d);
        chk("R6 word at 8", d, 32'h0000_0805);
        rd(4'd10, 3'd4, d);
        chk("R6 past end", d, 32'h0000_0000);
        rd(4'd3, 3'd1, d);
        chk("R6 R3 enabled high byte", d, 32'h0000_0081);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fixed_bytes();
        t_enable_mask();
        t_locations();
        t_lanes();
        t_reads();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule